// File: doc/BRIEF.md
# Twelve-Pin Masked-Window I/O Port with Pin Interrupts

This block is a general-purpose I/O port of up to twelve pins sitting on a simple word-addressed register bus. Software reaches the pin levels through a data window. In that window the byte-address bits 13:2 act as a per-pin access mask, so one access can read or update any subset of pins without a read-modify-write. Every other register holds one bit per pin. These set the pin direction, how each pin's interrupt is detected, which interrupts are enabled, and the raw and enabled interrupt status. A write-one-to-clear register acknowledges edge events.

Each pin input passes through a two-stage synchroniser. A per-pin detector then watches the synchronised level, either for edges (one polarity or both) or for a level held at a chosen polarity. The enabled status bits are ORed into a single registered interrupt line. Bus writes take effect on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr` and the current register state.

Top module: `mgpio_port`

## Requirements
- R1: After reset all pins are inputs (`pin_oe` = 0), the output latch is zero, `irq` is low, and every configuration and status register reads zero.
- R2: A read in the data window (byte offsets 0x0000 to 0x3FFC) returns the synchronised pin levels ANDed with address bits 13:2 (bit 2 gates pin 0). Address bits 1:0 are ignored and data bits 31:12 read zero.
- R3: A write in the data window changes the output latch (`pin_out`) only for pins whose address mask bit is set. All other pins keep their value.
- R4: The direction register at 0x8000 (1 = output) drives `pin_oe`. A data read returns the synchronised pin input even for a pin set as output.
- R5: With sense = 0 (edge) and both-edges = 0, a rising edge sets the pin's raw status bit when its event bit is 1, and a falling edge sets it when the event bit is 0. The opposite edge does nothing. Sense sits at 0x8004, both-edges at 0x8008, event at 0x800C and raw status at 0x8014.
- R6: With sense = 0 and both-edges = 1, either edge sets the raw bit and the event bit is ignored.
- R7: An edge-detected raw bit stays set until a 1 is written to that bit of the clear register at 0x801C. Writing 0 there leaves it unchanged.
- R8: With sense = 1 (level), the raw bit is 1 exactly while the synchronised pin equals the event bit. The clear register and the both-edges bit have no effect on it.
- R9: The masked status at 0x8018 is raw ANDed with the enable mask at 0x8010. `irq` is the registered OR of the masked status, so a raw event on a disabled pin never raises it.
- R10: Configuration registers keep only bits 11:0. Reads from offsets outside the data window and the eight registers return zero, and writes to them change no state.
- R11: A pin input change shows up in a data read two clock edges later, in the raw status one edge after that, and on `irq` one edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 16 | Byte address within the port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 12 | Asynchronous pin levels |
| pin_out | output | 12 | Output latch value |
| pin_oe | output | 12 | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong mask decode shows up at once on `pin_out` after a data-window write, or on the very next data read. Each of the 4096 read masks is swept, so a single mis-wired mask bit cannot hide. A detector in the wrong state, such as an edge latch that leaks or a level bit that latches, appears in the raw status three edges after the pin moves and on `irq` one edge later. Every pin is driven through each detection mode with rising and falling stimulus, so a fault tied to one pin or one polarity is caught within a few cycles. Clear writes of zero and of one are both followed by a status read, which shows whether an acknowledge reached the wrong detector or the wrong mode.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;

    parameter int unsigned PINS_DEFAULT = 12;
    parameter int unsigned ADDR_W       = 16;
    parameter int unsigned DATA_W       = 32;
    parameter int unsigned MASK_LSB     = 2;

    // register select, address bits 4:2 inside the control block
    typedef enum logic [2:0] {
        IDX_DIR   = 3'd0,
        IDX_SENSE = 3'd1,
        IDX_BOTH  = 3'd2,
        IDX_EVT   = 3'd3,
        IDX_MASK  = 3'd4,
        IDX_RAW   = 3'd5,
        IDX_MIS   = 3'd6,
        IDX_CLR   = 3'd7
    } reg_idx_e;

    // per-pin detector configuration
    typedef struct packed {
        logic sense;     // 1 = level, 0 = edge
        logic both;      // edge mode: any transition
        logic rise_hi;   // 1 = rising / high, 0 = falling / low
    } pin_cfg_t;

    function automatic logic [DATA_W-1:0] merge_masked(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [DATA_W-1:0] sel
    );
        return (old_v & ~sel) | (new_v & sel);
    endfunction

endpackage

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/mgpio_pin_irq.sv
module mgpio_pin_irq
    import mgpio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     smp,
    input  pin_cfg_t cfg,
    input  logic     clr,
    output logic     raw
);
    logic prev;
    logic rise, fall, edge_hit, lvl_hit;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= smp;
    end

    always_comb begin
        rise     = smp & ~prev;
        fall     = ~smp & prev;
        edge_hit = cfg.both ? (rise | fall) : (cfg.rise_hi ? rise : fall);
        lvl_hit  = (smp == cfg.rise_hi);
    end

    // level mode recomputes every cycle; edge mode latches until cleared,
    // a new edge in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (rst)            raw <= 1'b0;
        else if (cfg.sense) raw <= lvl_hit;
        else                raw <= edge_hit | (raw & ~clr);
    end
endmodule

// File: rtl/mgpio_port.sv
module mgpio_port
    import mgpio_pkg::*;
#(
    parameter int unsigned NPINS = PINS_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    localparam int unsigned IDX_LSB = 2;
    localparam int unsigned BLK_LSB = 5;

    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] dir_q, sense_q, both_q, evt_q, mask_q;
    logic [NPINS-1:0] raw_vec, clr_vec, win_mask, out_q;
    logic             irq_q;
    logic             in_data, in_ctl;
    reg_idx_e         idx;
    logic [DATA_W-1:0] merged;
    logic             unused_bits;

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:NPINS]};

    // address decode
    assign in_data  = (bus_addr[ADDR_W-1:ADDR_W-2] == 2'b00);
    assign in_ctl   = bus_addr[ADDR_W-1] && !bus_addr[ADDR_W-2]
                      && (bus_addr[ADDR_W-3:BLK_LSB] == '0);
    assign idx      = reg_idx_e'(bus_addr[IDX_LSB +: 3]);
    assign win_mask = bus_addr[MASK_LSB +: NPINS];

    assign clr_vec  = (bus_wr && in_ctl && idx == IDX_CLR) ? bus_wdata[NPINS-1:0] : '0;
    assign merged   = merge_masked(DATA_W'(out_q), bus_wdata, DATA_W'(win_mask));

    mgpio_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_cfg_t cfg_i;
        assign cfg_i = '{sense: sense_q[i], both: both_q[i], rise_hi: evt_q[i]};
        mgpio_pin_irq u_det (
            .clk (clk),
            .rst (rst),
            .smp (pin_sync[i]),
            .cfg (cfg_i),
            .clr (clr_vec[i]),
            .raw (raw_vec[i])
        );
    end

    // configuration and output latch
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            evt_q   <= '0;
            mask_q  <= '0;
            out_q   <= '0;
        end else if (bus_wr) begin
            if (in_data) begin
                out_q <= merged[NPINS-1:0];
            end else if (in_ctl) begin
                case (idx)
                    IDX_DIR:   dir_q   <= bus_wdata[NPINS-1:0];
                    IDX_SENSE: sense_q <= bus_wdata[NPINS-1:0];
                    IDX_BOTH:  both_q  <= bus_wdata[NPINS-1:0];
                    IDX_EVT:   evt_q   <= bus_wdata[NPINS-1:0];
                    IDX_MASK:  mask_q  <= bus_wdata[NPINS-1:0];
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(raw_vec & mask_q);
    end

    // read path
    always_comb begin
        bus_rdata = '0;
        if (in_data) begin
            bus_rdata[NPINS-1:0] = pin_sync & win_mask;
        end else if (in_ctl) begin
            case (idx)
                IDX_DIR:   bus_rdata[NPINS-1:0] = dir_q;
                IDX_SENSE: bus_rdata[NPINS-1:0] = sense_q;
                IDX_BOTH:  bus_rdata[NPINS-1:0] = both_q;
                IDX_EVT:   bus_rdata[NPINS-1:0] = evt_q;
                IDX_MASK:  bus_rdata[NPINS-1:0] = mask_q;
                IDX_RAW:   bus_rdata[NPINS-1:0] = raw_vec;
                IDX_MIS:   bus_rdata[NPINS-1:0] = raw_vec & mask_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = irq_q;
endmodule

// File: rtl/mgpio_port_chk.sv
module mgpio_port_chk
    import mgpio_pkg::*;
#(
    parameter int unsigned NPINS = PINS_DEFAULT
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic              irq,
    input logic [NPINS-1:0]  sync_v,
    input logic [NPINS-1:0]  raw_v,
    input logic [NPINS-1:0]  sense_v,
    input logic [NPINS-1:0]  evt_v,
    input logic [NPINS-1:0]  mask_v,
    input logic [NPINS-1:0]  clr_v
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0 && !irq));

    a_r10_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:NPINS] == '0);

    a_r9_irq_low: assert property (@(posedge clk) disable iff (rst)
        ((raw_v & mask_v) == '0) |=> !irq);

    a_r9_irq_high: assert property (@(posedge clk) disable iff (rst)
        ((raw_v & mask_v) != '0) |=> irq);

    for (genvar i = 0; i < NPINS; i++) begin : g_bit
        a_r7_edge_hold: assert property (@(posedge clk) disable iff (rst)
            (!sense_v[i] && raw_v[i] && !clr_v[i]) |=> raw_v[i]);

        a_r8_level_track: assert property (@(posedge clk) disable iff (rst)
            sense_v[i] |=> (raw_v[i] == ($past(sync_v[i]) == $past(evt_v[i]))));

        a_r3_unmasked_keep: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr[ADDR_W-1:ADDR_W-2] == 2'b00 && !bus_addr[MASK_LSB + i])
            |=> $stable(pin_out[i]));
    end
endmodule

bind mgpio_port mgpio_port_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .sync_v    (pin_sync),
    .raw_v     (raw_vec),
    .sense_v   (sense_q),
    .evt_v     (evt_q),
    .mask_v    (mask_q),
    .clr_v     (clr_vec)
);

// File: tb/mgpio_port_bench.sv
module mgpio_port_bench;
    localparam int N = 12;
    localparam logic [15:0] A_DIR = 16'h8000, A_SEN = 16'h8004, A_BTH = 16'h8008,
                            A_EVT = 16'h800C, A_MSK = 16'h8010, A_RAW = 16'h8014,
                            A_MIS = 16'h8018, A_CLR = 16'h801C, A_ALL = 16'h3FFC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [N-1:0] out_model = '0;

    always #5 clk = ~clk;

    mgpio_port u_mgpio_port (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pin(input int i, input logic v);
        @(negedge clk);
        pin_in[i] = v;
        cyc(5);
    endtask

    task automatic chk_reg(input string req, input logic [15:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic pin_scenarios(input int i);
        logic [31:0] b;
        b = 32'(1) << i;
        wr(A_SEN, 0); wr(A_BTH, 0); wr(A_EVT, 0); wr(A_MSK, 0);
        wr(A_CLR, 32'hFFF); cyc(2);
        chk_reg("R7 cleared start", A_RAW, 0);
        // R5 rising single edge
        wr(A_EVT, b); wr(A_MSK, b);
        set_pin(i, 1);
        chk_reg("R5 rising sets raw", A_RAW, b);
        chk_reg("R9 masked status", A_MIS, b);
        chk("R9 irq high", 32'(irq), 1);
        set_pin(i, 0);
        chk_reg("R7 held over falling", A_RAW, b);
        wr(A_CLR, 0); cyc(2);
        chk_reg("R7 clear zero no effect", A_RAW, b);
        wr(A_CLR, b); cyc(2);
        chk_reg("R7 clear one", A_RAW, 0);
        chk("R9 irq low after clear", 32'(irq), 0);
        // R5 falling single edge
        wr(A_EVT, 0);
        set_pin(i, 1);
        chk_reg("R5 rising ignored when falling selected", A_RAW, 0);
        set_pin(i, 0);
        chk_reg("R5 falling sets raw", A_RAW, b);
        wr(A_CLR, b); cyc(2);
        // R6 both edges
        wr(A_BTH, b);
        set_pin(i, 1);
        chk_reg("R6 rise with both", A_RAW, b);
        wr(A_CLR, b); cyc(2);
        wr(A_EVT, b);
        set_pin(i, 0);
        chk_reg("R6 fall with both, event ignored", A_RAW, b);
        wr(A_CLR, b); cyc(2);
        // R9 disabled pin
        wr(A_BTH, 0); wr(A_MSK, 0);
        set_pin(i, 1);
        chk_reg("R9 raw without enable", A_RAW, b);
        chk_reg("R9 masked zero", A_MIS, 0);
        chk("R9 irq stays low", 32'(irq), 0);
        set_pin(i, 0);
        wr(A_CLR, b); cyc(2);
        // R8 level mode, both-edges set to show it is ignored
        wr(A_SEN, b); wr(A_EVT, b); wr(A_MSK, b); wr(A_BTH, b); cyc(3);
        chk_reg("R8 high level not present", A_RAW, 0);
        set_pin(i, 1);
        chk_reg("R8 high level raw", A_RAW, b);
        chk("R8 irq on level", 32'(irq), 1);
        wr(A_CLR, b); cyc(2);
        chk_reg("R8 clear no effect", A_RAW, b);
        set_pin(i, 0);
        chk_reg("R8 level released", A_RAW, 0);
        chk("R8 irq released", 32'(irq), 0);
        wr(A_EVT, 0); cyc(3);
        chk_reg("R8 low level raw", A_RAW, b);
        wr(A_MSK, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired got running expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        cyc(3);
        @(negedge clk) rst = 1'b0;
        cyc(1);
        // R1 reset state
        chk("R1 pin_oe", 32'(pin_oe), 0);
        chk("R1 pin_out", 32'(pin_out), 0);
        chk("R1 irq", 32'(irq), 0);
        for (int k = 0; k < 7; k++) chk_reg("R1 register zero", 16'h8000 + 16'(4 * k), 0);

        // R11 latency and R2 exhaustive read sweep
        @(negedge clk) pin_in = 12'hA5C;
        @(negedge clk); rd(A_ALL, d); chk("R11 one edge still old", d, 0);
        @(negedge clk); rd(A_ALL, d); chk("R11 two edges new", d, 32'hA5C);
        for (int m = 0; m < 4096; m++) begin
            rd({2'b00, 12'(m), 2'(m)}, d);
            chk("R2 masked read", d, 32'(m & 12'hA5C));
        end

        // R3 masked write sweep
        for (int k = 0; k < 64; k++) begin
            logic [11:0] m, v;
            m = 12'((k * 1117 + 3) % 4096);
            v = 12'((k * 2731) ^ 12'h5A5);
            wr({2'b00, m, 2'b00}, {20'hFFFFF, v});
            out_model = (out_model & ~m) | (v & m);
            chk("R3 masked write", 32'(pin_out), 32'(out_model));
        end
        wr(16'h0000, 32'hFFF);
        chk("R3 empty mask write", 32'(pin_out), 32'(out_model));

        // R4 direction and read of driven pins
        wr(A_DIR, 32'hF0F);
        chk("R4 pin_oe", 32'(pin_oe), 32'hF0F);
        @(negedge clk) pin_in = 12'h0A5;
        cyc(3);
        chk_reg("R4 read returns input", A_ALL, 32'h0A5);
        chk_reg("R4 direction readback", A_DIR, 32'hF0F);

        // R10 widths and unmapped offsets
        wr(A_SEN, 32'hFFFF_FFFF);
        chk_reg("R10 register width", A_SEN, 32'hFFF);
        wr(A_SEN, 0);
        wr(16'h4FFC, 32'hFFF);
        chk("R10 window alias write ignored", 32'(pin_out), 32'(out_model));
        wr(16'h8020, 32'hFFF);
        chk_reg("R10 hole write ignored", A_DIR, 32'hF0F);
        chk_reg("R10 read 0x4FFC", 16'h4FFC, 0);
        chk_reg("R10 read 0x8020", 16'h8020, 0);
        chk_reg("R10 read 0xC000", 16'hC000, 0);
        chk_reg("R10 read clear reg", A_CLR, 0);

        // interrupts per pin
        @(negedge clk) pin_in = '0;
        cyc(5);
        for (int i = 0; i < N; i++) pin_scenarios(i);

        // R11 interrupt timing: raw after 3 edges, irq after 4
        wr(A_SEN, 0); wr(A_BTH, 0); wr(A_EVT, 32'h1); wr(A_MSK, 32'h1);
        wr(A_CLR, 32'hFFF); cyc(2);
        @(negedge clk) pin_in[0] = 1'b1;
        cyc(2); rd(A_RAW, d); chk("R11 raw not yet", d, 0);
        cyc(1); rd(A_RAW, d); chk("R11 raw after three edges", d, 1);
        chk("R11 irq not yet", 32'(irq), 0);
        cyc(1); chk("R11 irq after four edges", 32'(irq), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule